// File: doc/BRIEF.md
# Trigger Input Coincidence and Catch Unit

This block turns sixteen external trigger lines into one raw trigger. First each line passes through a two-stage synchronizer. In the default mode the raw trigger is the OR of the enabled lines, and each line can be inverted before that OR. In coincidence mode the raw trigger comes from two programmable AND units instead. Each unit has its own input-enable mask and its own input-invert mask, plus an output invert. With these, a unit can also act as an OR gate through De Morgan's law. In both modes, a gated oscillator trigger and a command trigger are ORed into the result.

The block also produces three observation words that share one bit layout:
- a live status word;
- a sticky catch word, which records every signal seen high since it was last cleared;
- a pre-busy catch word, which records signals only while busy is low.

Each catch word has a single-cycle clear strobe. A signal that is high in the same cycle as a clear stays recorded.

Top module: `trig_coinc_catch`

## Requirements
- R1: Each bit of `ext_trig_i` appears in `status_o[15:0]` after exactly two rising clock edges. Reset clears the synchronizer, `catch_o` and `pbcatch_o` to zero.
- R2: With `coinc_mode_i` low, the OR term is true when any synchronized input `i` with `ext_en_i[i]=1` has `input XOR in_inv_i[i]` equal to 1. The term is `raw_trig_o`, and it is also ORed with `osc_trig_i & osc_en_i` and with `cmd_trig_i`.
- R3: With `coinc_mode_i` high, the term is `(unit0 & unit_en_i[0]) | (unit1 & unit_en_i[1])` in place of the OR term. In this mode `ext_en_i` and `in_inv_i` have no effect.
- R4: Unit u takes its config word, in which bits 15:0 enable inputs and bits 31:16 invert them. It ANDs `input XOR invert` over every enabled input, then XORs the result with `unit_out_inv_i[u]`. Unit 0 uses `and0_cfg_i` and unit 1 uses `and1_cfg_i`. Both units are evaluated in either mode.
- R5: A unit with no input enabled produces 0 before its output invert.
- R6: The layout of `status_o` is as follows. Bits 15:0 are the synchronized inputs. Bit 21 is the raw trigger. Bit 22 is `cmd_trig_i`. Bit 23 is the OR of all synchronized inputs, with no masking and no inversion. Bit 24 is `osc_trig_i`, ungated. Bits 25 and 26 are the outputs of unit 0 and unit 1. All other bits read 0.
- R7: On each clock edge, `catch_o` takes the OR of its old value and `status_o`.
- R8: After an edge with `catch_clr_i` high, `catch_o` equals the `status_o` seen at that edge.
- R9: On each edge with `busy_i` low, `pbcatch_o` ORs in `status_o`. On edges with `busy_i` high and no clear, `pbcatch_o` holds its value.
- R10: After an edge with `pbcatch_clr_i` high, `pbcatch_o` equals `status_o` if `busy_i` was low at that edge, and 0 if `busy_i` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_trig_i | input | 16 | Asynchronous external trigger lines |
| osc_trig_i | input | 1 | Internal oscillator trigger (synchronous) |
| cmd_trig_i | input | 1 | Command trigger (synchronous) |
| busy_i | input | 1 | Busy; freezes the pre-busy catch word |
| ext_en_i | input | 16 | Per-line enables for OR mode |
| in_inv_i | input | 16 | Per-line inverts for OR mode |
| osc_en_i | input | 1 | Oscillator trigger enable |
| unit_en_i | input | 2 | Enables for the outputs of AND units 0 and 1 |
| unit_out_inv_i | input | 2 | Output inverts of AND units 0 and 1 |
| and0_cfg_i | input | 32 | Unit 0: bits 31:16 are inverts, bits 15:0 are enables |
| and1_cfg_i | input | 32 | Unit 1: bits 31:16 are inverts, bits 15:0 are enables |
| coinc_mode_i | input | 1 | 1 selects the AND units, 0 selects the OR path |
| catch_clr_i | input | 1 | Clear strobe for the catch word |
| pbcatch_clr_i | input | 1 | Clear strobe for the pre-busy catch word |
| raw_trig_o | output | 1 | Raw trigger |
| status_o | output | 32 | Live status word |
| catch_o | output | 32 | Sticky catch word |
| pbcatch_o | output | 32 | Pre-busy catch word |

## Verification
A clear strobe and a new event can land on the same edge, so the catch registers must settle a race between erasing and recording. The bench holds an input high and then raises `catch_clr_i` for one cycle. It expects the catch word afterwards to equal exactly the live status of that edge: stale bits are gone and the live bits are kept. For the pre-busy word it repeats this twice, once with busy low and once with busy high. It expects the current status in the first case and zero in the second.

// File: rtl/trig_cc_pkg.sv
package trig_cc_pkg;

    localparam int N_EXT       = 16;
    localparam int N_UNITS     = 2;
    localparam int SYNC_STAGES = 2;
    localparam int STAT_W      = 32;
    localparam int CFG_W       = 2 * N_EXT;

    // Status word bit positions (shared by live, catch and pre-busy words)
    localparam int ST_RAW = 21;
    localparam int ST_CMD = 22;
    localparam int ST_ANY = 23;
    localparam int ST_OSC = 24;
    localparam int ST_U0  = 25;

    typedef struct packed {
        logic [N_EXT-1:0] inv;
        logic [N_EXT-1:0] en;
    } unit_cfg_t;

    typedef struct packed {
        logic [N_EXT-1:0]   lvl;
        logic               raw;
        logic               cmd;
        logic               osc;
        logic [N_UNITS-1:0] unit;
    } trig_view_t;

    function automatic logic [STAT_W-1:0] pack_status(input trig_view_t v);
        logic [STAT_W-1:0] s;
        s = '0;
        s[N_EXT-1:0] = v.lvl;
        s[ST_RAW]    = v.raw;
        s[ST_CMD]    = v.cmd;
        s[ST_ANY]    = |v.lvl;
        s[ST_OSC]    = v.osc;
        for (int u = 0; u < N_UNITS; u++) begin
            s[ST_U0 + u] = v.unit[u];
        end
        return s;
    endfunction

endpackage

// File: rtl/trig_in_sync.sv
module trig_in_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/coinc_and.sv
module coinc_and #(
    parameter int W = 16
) (
    input  logic [W-1:0] in_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] inv_i,
    input  logic         out_inv_i,
    output logic         out_o
);
    logic [W-1:0] term;
    logic         core;

    always_comb begin
        term = ~en_i | (in_i ^ inv_i);
        core = (|en_i) & (&term);
        out_o = core ^ out_inv_i;
    end
endmodule

// File: rtl/sticky_catch.sv
module sticky_catch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         capture_i,
    input  logic [W-1:0] sample_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] kept;
    logic [W-1:0] taken;

    always_comb begin
        kept  = clr_i ? '0 : q_o;
        taken = capture_i ? sample_i : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= kept | taken;
    end
endmodule

// File: rtl/trig_coinc_catch.sv
module trig_coinc_catch
    import trig_cc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_EXT-1:0]  ext_trig_i,
    input  logic              osc_trig_i,
    input  logic              cmd_trig_i,
    input  logic              busy_i,
    input  logic [N_EXT-1:0]  ext_en_i,
    input  logic [N_EXT-1:0]  in_inv_i,
    input  logic              osc_en_i,
    input  logic [N_UNITS-1:0] unit_en_i,
    input  logic [N_UNITS-1:0] unit_out_inv_i,
    input  logic [CFG_W-1:0]  and0_cfg_i,
    input  logic [CFG_W-1:0]  and1_cfg_i,
    input  logic              coinc_mode_i,
    input  logic              catch_clr_i,
    input  logic              pbcatch_clr_i,
    output logic              raw_trig_o,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] catch_o,
    output logic [STAT_W-1:0] pbcatch_o
);
    logic [N_EXT-1:0]   ext_s;
    unit_cfg_t          ucfg [N_UNITS];
    logic [N_UNITS-1:0] unit_out;
    logic               or_path;
    logic               and_path;
    trig_view_t         view;

    trig_in_sync #(.W(N_EXT), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ext_trig_i),
        .q_o (ext_s)
    );

    assign ucfg[0] = unit_cfg_t'(and0_cfg_i);
    assign ucfg[1] = unit_cfg_t'(and1_cfg_i);

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        coinc_and #(.W(N_EXT)) u_and (
            .in_i      (ext_s),
            .en_i      (ucfg[u].en),
            .inv_i     (ucfg[u].inv),
            .out_inv_i (unit_out_inv_i[u]),
            .out_o     (unit_out[u])
        );
    end

    always_comb begin
        or_path    = |((ext_s ^ in_inv_i) & ext_en_i);
        and_path   = |(unit_out & unit_en_i);
        raw_trig_o = (coinc_mode_i ? and_path : or_path)
                   | (osc_trig_i & osc_en_i) | cmd_trig_i;
        view.lvl   = ext_s;
        view.raw   = raw_trig_o;
        view.cmd   = cmd_trig_i;
        view.osc   = osc_trig_i;
        view.unit  = unit_out;
        status_o   = pack_status(view);
    end

    sticky_catch #(.W(STAT_W)) u_catch (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (catch_clr_i),
        .capture_i (1'b1),
        .sample_i  (status_o),
        .q_o       (catch_o)
    );

    sticky_catch #(.W(STAT_W)) u_pbcatch (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (pbcatch_clr_i),
        .capture_i (~busy_i),
        .sample_i  (status_o),
        .q_o       (pbcatch_o)
    );
endmodule

// File: rtl/trig_cc_checker.sv
module trig_cc_checker (
    input logic        clk,
    input logic        rst,
    input logic        busy_i,
    input logic        catch_clr_i,
    input logic        pbcatch_clr_i,
    input logic        coinc_mode_i,
    input logic [15:0] ext_en_i,
    input logic        osc_en_i,
    input logic        cmd_trig_i,
    input logic [1:0]  unit_out_inv_i,
    input logic [31:0] and0_cfg_i,
    input logic        raw_trig_o,
    input logic [31:0] status_o,
    input logic [31:0] catch_o,
    input logic [31:0] pbcatch_o
);
    assert_catch_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !catch_clr_i |=> ((catch_o & $past(catch_o)) == $past(catch_o)));

    assert_catch_take_R7: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((catch_o & $past(status_o)) == $past(status_o)));

    assert_catch_clear_R8: assert property (@(posedge clk) disable iff (rst)
        catch_clr_i |=> (catch_o == $past(status_o)));

    assert_pb_freeze_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_i && !pbcatch_clr_i) |=> (pbcatch_o == $past(pbcatch_o)));

    assert_pb_take_R9: assert property (@(posedge clk) disable iff (rst)
        !busy_i |=> ((pbcatch_o & $past(status_o)) == $past(status_o)));

    assert_pb_clear_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (pbcatch_clr_i && busy_i) |=> (pbcatch_o == 32'h0));

    assert_empty_unit_R5: assert property (@(posedge clk) disable iff (rst)
        (and0_cfg_i[15:0] == 16'h0) |-> (status_o[25] == unit_out_inv_i[0]));

    assert_or_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!coinc_mode_i && ext_en_i == 16'h0 && !osc_en_i && !cmd_trig_i) |-> !raw_trig_o);

    assert_unused_zero_R6: assert property (@(posedge clk) disable iff (rst)
        !rst |-> (status_o[20:16] == 5'h0 && status_o[31:27] == 5'h0));
endmodule

bind trig_coinc_catch trig_cc_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .busy_i         (busy_i),
    .catch_clr_i    (catch_clr_i),
    .pbcatch_clr_i  (pbcatch_clr_i),
    .coinc_mode_i   (coinc_mode_i),
    .ext_en_i       (ext_en_i),
    .osc_en_i       (osc_en_i),
    .cmd_trig_i     (cmd_trig_i),
    .unit_out_inv_i (unit_out_inv_i),
    .and0_cfg_i     (and0_cfg_i),
    .raw_trig_o     (raw_trig_o),
    .status_o       (status_o),
    .catch_o        (catch_o),
    .pbcatch_o      (pbcatch_o)
);

// File: tb/trig_coinc_catch_tb.sv
module trig_coinc_catch_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ext = '0;
    logic        osc = 1'b0, cmd = 1'b0, busy = 1'b0;
    logic [15:0] en = '0, inv = '0;
    logic        osc_en = 1'b0;
    logic [1:0]  uen = '0, uoinv = '0;
    logic [31:0] a0 = '0, a1 = '0;
    logic        mode = 1'b0, cclr = 1'b0, pclr = 1'b0;
    logic        raw;
    logic [31:0] stat, catchw, pbw;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    trig_coinc_catch u_dut (
        .clk(clk), .rst(rst), .ext_trig_i(ext), .osc_trig_i(osc), .cmd_trig_i(cmd),
        .busy_i(busy), .ext_en_i(en), .in_inv_i(inv), .osc_en_i(osc_en),
        .unit_en_i(uen), .unit_out_inv_i(uoinv), .and0_cfg_i(a0), .and1_cfg_i(a1),
        .coinc_mode_i(mode), .catch_clr_i(cclr), .pbcatch_clr_i(pclr),
        .raw_trig_o(raw), .status_o(stat), .catch_o(catchw), .pbcatch_o(pbw)
    );

    // Expected unit output per R4/R5
    function automatic logic unit_exp(input logic [31:0] cfg, input logic oinv, input logic [15:0] x);
        logic c;
        if (cfg[15:0] == 16'h0) c = 1'b0;
        else c = &((x ^ cfg[31:16]) | ~cfg[15:0]);
        return c ^ oinv;
    endfunction

    // Expected status per R2/R3/R6, for settled input x
    function automatic logic [31:0] exp_status(input logic [15:0] x);
        logic [31:0] s;
        logic u0, u1, r;
        u0 = unit_exp(a0, uoinv[0], x);
        u1 = unit_exp(a1, uoinv[1], x);
        if (mode) r = (u0 & uen[0]) | (u1 & uen[1]);
        else      r = |((x ^ inv) & en);
        r = r | (osc & osc_en) | cmd;
        s = '0;
        s[15:0] = x; s[21] = r; s[22] = cmd; s[23] = |x; s[24] = osc;
        s[25] = u0; s[26] = u1;
        return s;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Drive inputs at a falling edge, then let the two sync stages settle
    task automatic apply(input logic [15:0] x);
        @(negedge clk); ext = x;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic idle_cfg();
        @(negedge clk);
        en = '0; inv = '0; osc_en = 0; uen = '0; uoinv = '0; a0 = '0; a1 = '0;
        mode = 0; osc = 0; cmd = 0; busy = 0;
    endtask

    task automatic t_reset_R1();
        chk("R1 reset status", stat, 32'h0);
        chk("R1 reset catch", catchw, 32'h0);
        chk("R1 reset pbcatch", pbw, 32'h0);
    endtask

    task automatic t_sync_R1();
        @(negedge clk); ext = 16'h0001;
        @(negedge clk);
        chk("R1 one edge not visible", {31'h0, stat[0]}, 32'h0);
        @(negedge clk);
        chk("R1 two edges visible", {31'h0, stat[0]}, 32'h1);
        apply(16'h0);
    endtask

    task automatic t_or_R2();
        idle_cfg(); en = 16'h00F0;
        apply(16'h0010);
        chk("R2 enabled line", {31'h0, raw}, 32'h1);
        chk("R6 status or", stat, exp_status(16'h0010));
        apply(16'h0100);
        chk("R2 disabled line", {31'h0, raw}, 32'h0);
        chk("R6 any bit unmasked", stat, exp_status(16'h0100));
        @(negedge clk); inv = 16'h0020;
        apply(16'h0000);
        chk("R2 inverted idle line", {31'h0, raw}, 32'h1);
    endtask

    task automatic t_coinc_R3();
        idle_cfg(); mode = 1; uen = 2'b01; a0 = 32'h0000_0003; en = 16'hFFFF;
        apply(16'h0003);
        chk("R3 coincidence met", {31'h0, raw}, 32'h1);
        apply(16'h0001);
        chk("R3 partial, OR enables ignored", {31'h0, raw}, 32'h0);
        chk("R4 status coinc", stat, exp_status(16'h0001));
        @(negedge clk); inv = 16'hFFFF;
        @(negedge clk);
        chk("R3 OR inverts ignored", {31'h0, raw}, 32'h0);
        @(negedge clk); uen = 2'b00;
        apply(16'h0003);
        chk("R3 unit disabled", {31'h0, raw}, 32'h0);
    endtask

    task automatic t_demorgan_R4();
        idle_cfg(); mode = 1; uen = 2'b01; a0 = 32'h0003_0003; uoinv = 2'b01;
        apply(16'h0000);
        chk("R4 or-form idle", {31'h0, stat[25]}, 32'h0);
        apply(16'h0002);
        chk("R4 or-form one input", {31'h0, raw}, 32'h1);
        chk("R4 status or-form", stat, exp_status(16'h0002));
        @(negedge clk); a1 = 32'h0004_000C;
        apply(16'h0008);
        chk("R4 unit1 mixed invert", {31'h0, stat[26]}, 32'h1);
    endtask

    task automatic t_empty_R5();
        idle_cfg(); mode = 1; uen = 2'b10;
        apply(16'hFFFF);
        chk("R5 empty unit zero", {31'h0, stat[26]}, 32'h0);
        chk("R5 empty unit no trigger", {31'h0, raw}, 32'h0);
        @(negedge clk); uoinv = 2'b10;
        @(negedge clk);
        chk("R5 empty unit inverted", {31'h0, raw}, 32'h1);
        apply(16'h0);
    endtask

    task automatic t_osc_cmd_R6();
        idle_cfg(); osc = 1;
        @(negedge clk);
        chk("R6 osc ungated status", stat, exp_status(16'h0));
        chk("R2 osc gated off", {31'h0, raw}, 32'h0);
        osc_en = 1;
        @(negedge clk);
        chk("R2 osc enabled", {31'h0, raw}, 32'h1);
        osc = 0; cmd = 1;
        @(negedge clk);
        chk("R6 cmd bit", stat, exp_status(16'h0));
        cmd = 0;
    endtask

    task automatic t_catch_R7();
        idle_cfg(); cclr = 1;
        @(negedge clk); cclr = 0;
        @(negedge clk); ext = 16'h0020;
        @(negedge clk); ext = 16'h0000;
        repeat (4) @(negedge clk);
        chk("R7 pulse caught", catchw, 32'h0080_0020);
        chk("R7 status gone", stat, 32'h0);
    endtask

    task automatic t_clear_R8();
        idle_cfg(); en = 16'h0008;
        apply(16'h0008);
        cclr = 1;
        @(negedge clk); cclr = 0;
        chk("R8 clear keeps live bits", catchw, exp_status(16'h0008));
        apply(16'h0000);
        cclr = 1;
        @(negedge clk); cclr = 0;
        chk("R8 clear when idle", catchw, 32'h0);
    endtask

    task automatic t_pb_R9();
        idle_cfg(); pclr = 1;
        @(negedge clk); pclr = 0; busy = 1;
        @(negedge clk); ext = 16'h0080;
        @(negedge clk); ext = 16'h0000;
        repeat (4) @(negedge clk);
        chk("R9 frozen under busy", pbw, 32'h0);
        chk("R7 catch still sees pulse", catchw & 32'h0000_0080, 32'h0000_0080);
        busy = 0; ext = 16'h0200;
        repeat (4) @(negedge clk);
        chk("R9 captures when not busy", pbw, 32'h0080_0200);
        apply(16'h0);
    endtask

    task automatic t_pbclr_R10();
        idle_cfg();
        apply(16'h0004);
        pclr = 1;
        @(negedge clk); pclr = 0;
        chk("R10 clear keeps live bits", pbw, exp_status(16'h0004));
        busy = 1; pclr = 1;
        @(negedge clk); pclr = 0;
        chk("R10 clear under busy", pbw, 32'h0);
        @(negedge clk);
        chk("R10 stays clear under busy", pbw, 32'h0);
        busy = 0;
        apply(16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_R1();
        rst = 0;
        t_sync_R1();
        t_or_R2();
        t_coinc_R3();
        t_demorgan_R4();
        t_empty_R5();
        t_osc_cmd_R6();
        t_catch_R7();
        t_clear_R8();
        t_pb_R9();
        t_pbclr_R10();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule